// File: doc/BRIEF.md
# Six-Lane Capture Buffer with Serial Burst Readout

The block records six parallel sample lanes into six memory banks of 256 words each while a slow write window is open. One word per lane is stored on every write-clock edge. When the window closes, the complementary read window opens in the fast read-clock domain. An 11-bit sequence counter then walks through eight bank slots of 256 words each and places them on a single output word. Slots 0 to 5 carry the six banks, and slots 6 and 7 carry zero padding. The low eight counter bits form the word address and the top three bits pick the slot, so the slot changes once every 256 read clocks.

A full sweep takes 2048 read clocks, which is shorter than the read window. The counter therefore stops on its terminal count, raises a done flag, and holds its value for the rest of the window. The window control is a single level input: high means write and low means read. It reaches the read domain through a two-stage synchroniser. The next write window clears the counter and the done flag.

Top module: `bank_burst_reader`

## Requirements
- R1: While `wr_win` is high, every rising `wr_clk` edge stores lane b of `wr_lanes` (bits b*8 upward) into bank b, at word addresses 0, 1, 2, … in turn. The address restarts at 0 in every new write window.
- R2: After 256 words in one window, the write address saturates. Later samples in the same window are ignored and do not overwrite stored words.
- R3: `wr_win` falls at a `rd_clk` falling edge. The first valid word is then present after the 4th following `rd_clk` rising edge. The 2-stage synchroniser, the start detect and the registered read each take one edge.
- R4: The output order is word index k = 0..2047, with slot = k[10:8] and address = k[7:0]. Slots 0–5 give bank 0–5 at that address. Slots 6 and 7 give 0.
- R5: Exactly 2048 consecutive cycles have `rd_valid` high in each read window. `rd_done` rises on the same edge that presents the last word.
- R6: Once done, the sequence is frozen for the rest of the read window. No further valid words appear, and the counter and slot select hold their values.
- R7: `rd_done` stays high until the 3rd `rd_clk` rising edge after `wr_win` rises, and is low after that edge.
- R8: `rd_data` is 0 whenever `rd_valid` is low, and `rd_valid` is low throughout the write window.
- R9: While `rst_n` is low, `rd_valid`, `rd_done` and `rd_data` are 0, and no read sequence starts until a full write-then-read window pair has occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_clk | input | 1 | Slow capture clock |
| wr_win | input | 1 | High: write window; low: read window |
| wr_lanes | input | BANKS*DATA_W (48) | Six sample lanes, lane b at bits b*DATA_W upward |
| rd_clk | input | 1 | Fast readout clock |
| rd_data | output | DATA_W (8) | Serial output word |
| rd_valid | output | 1 | Output word is part of the burst |
| rd_done | output | 1 | All eight slots have been sent |

## Verification
The write clock runs at one third of the read clock, and the two are phase-aligned. Every window change and lane update therefore happens on a falling edge of both clocks, which makes the cross-domain latencies exact. A sample driven before a write-clock rising edge is stored on that edge. After the window falls, the first valid word is due after the 4th read-clock rising edge and the last word and done after the 2051st. After the window rises, done clears after the 3rd. The bench counts read-clock falling edges from the window change and compares valid, done and data against that schedule on every edge. It uses the burst order and the stored lane patterns, including samples past the 256th that must be discarded.

// File: rtl/bank_burst_reader.sv
module bank_burst_reader #(
  parameter int DATA_W = 8,
  parameter int BANKS  = 6,
  parameter int ADDR_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic                    rst_n,
  input  logic                    wr_clk,
  input  logic                    wr_win,
  input  logic [BANKS*DATA_W-1:0] wr_lanes,
  input  logic                    rd_clk,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    rd_valid,
  output logic                    rd_done
);

  localparam int SEQ_W = ADDR_W + SEL_W;
  localparam int MEM_N = BANKS << ADDR_W;
  localparam logic [ADDR_W-1:0] ADDR_LAST = '1;
  localparam logic [SEQ_W-1:0]  SEQ_LAST  = '1;
  localparam logic [SEL_W-1:0]  PAD_SLOT  = BANKS[SEL_W-1:0];

  logic [DATA_W-1:0] mem [MEM_N];

  logic [ADDR_W-1:0] wr_addr;
  logic              wr_full;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr <= '0;
      wr_full <= 1'b0;
    end else if (!wr_win) begin
      wr_addr <= '0;
      wr_full <= 1'b0;
    end else if (!wr_full) begin
      wr_full <= (wr_addr == ADDR_LAST);
      if (wr_addr != ADDR_LAST) wr_addr <= wr_addr + 1'b1;
    end
  end

  always_ff @(posedge wr_clk) begin
    if (wr_win && !wr_full) begin
      for (int b = 0; b < BANKS; b++)
        mem[{SEL_W'(b), wr_addr}] <= wr_lanes[b*DATA_W +: DATA_W];
    end
  end

  logic [2:0]        win_sync;
  logic              active;
  logic              term;
  logic [SEQ_W-1:0]  seq;

  wire rd_open = win_sync[2] & ~win_sync[1];
  wire [SEL_W-1:0] slot = seq[SEQ_W-1:ADDR_W];

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) win_sync <= '0;
    else        win_sync <= {win_sync[1:0], wr_win};
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      term   <= 1'b0;
      seq    <= '0;
    end else if (win_sync[1]) begin
      active <= 1'b0;
      term   <= 1'b0;
      seq    <= '0;
    end else if (rd_open && !term) begin
      active <= 1'b1;
    end else if (active) begin
      if (seq == SEQ_LAST) begin
        active <= 1'b0;
        term   <= 1'b1;
      end else begin
        seq <= seq + 1'b1;
      end
    end
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= active;
      rd_data  <= (active && slot < PAD_SLOT) ? mem[seq] : '0;
    end
  end

  assign rd_done = term;

endmodule

module bank_burst_reader_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int SEQ_W  = 11
) (
  input logic              rst_n,
  input logic              wr_clk,
  input logic              rd_clk,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              rd_done,
  input logic              active,
  input logic [SEQ_W-1:0]  seq,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_full
);

  assert_idle_zero_R8: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == '0);

  assert_seq_step_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (active && $past(active)) |-> seq == SEQ_W'($past(seq) + 1'b1));

  assert_done_last_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $rose(rd_done) |-> (rd_valid && seq == '1));

  assert_done_freeze_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_done && $past(rd_done)) |-> ($stable(seq) && !rd_valid));

  assert_wr_saturate_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_full && $past(wr_full)) |-> ($stable(wr_addr) && wr_addr == '1));

endmodule

bind bank_burst_reader bank_burst_reader_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)
) u_chk (
  .rst_n(rst_n), .wr_clk(wr_clk), .rd_clk(rd_clk),
  .rd_data(rd_data), .rd_valid(rd_valid), .rd_done(rd_done),
  .active(active), .seq(seq), .wr_addr(wr_addr), .wr_full(wr_full)
);

// File: tb/bank_burst_reader_bench.sv
`timescale 1ns/1ps
module bank_burst_reader_bench;

  localparam int DW = 8;
  localparam int NB = 6;
  localparam int RD_WIN = 2300;

  logic          rst_n = 1'b0;
  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          wr_win = 1'b0;
  logic [NB*DW-1:0] wr_lanes = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          rd_done;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #2 rd_clk = ~rd_clk;
  always #6 wr_clk = ~wr_clk;

  bank_burst_reader u_bank_burst_reader (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_win(wr_win), .wr_lanes(wr_lanes),
    .rd_clk(rd_clk), .rd_data(rd_data), .rd_valid(rd_valid), .rd_done(rd_done)
  );

  function automatic logic [7:0] pat(int f, int b, int i);
    int v = f*37 + b*53 + i*7 + 1;
    if (i >= 256) v = v ^ 8'hA5;
    return v[7:0];
  endfunction

  function automatic logic [7:0] expect_word(int f, int k);
    int s = k / 256;
    if (s >= NB) return 8'h00;
    return pat(f, s, k % 256);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_frame(int f, int n, bit prev_read);
    @(negedge wr_clk);
    wr_win = 1'b1;
    for (int b = 0; b < NB; b++) wr_lanes[b*DW +: DW] = pat(f, b, 0);
    if (prev_read) begin
      @(negedge rd_clk);
      @(negedge rd_clk);
      check(rd_done == 1'b1, "R7 done held two edges into write", rd_done, 1);
    end
    for (int i = 1; i < n; i++) begin
      @(negedge wr_clk);
      if (i == 1 && prev_read)
        check(rd_done == 1'b0, "R7 done cleared third edge", rd_done, 0);
      check(rd_valid == 1'b0, "R8 no valid in write window", rd_valid, 0);
      for (int b = 0; b < NB; b++) wr_lanes[b*DW +: DW] = pat(f, b, i);
    end
  endtask

  task automatic read_frame(int f);
    @(negedge wr_clk);
    wr_win = 1'b0;
    for (int n = 1; n <= RD_WIN; n++) begin
      bit ev, ed;
      logic [7:0] exp_d;
      @(negedge rd_clk);
      ev = (n >= 4 && n <= 2051);
      ed = (n >= 2051);
      exp_d = ev ? expect_word(f, n - 4) : 8'h00;
      check(rd_valid == ev, ev ? "R3 R5 valid expected" : "R5 R6 valid not expected", rd_valid, ev);
      check(rd_done == ed, "R5 R6 done timing", rd_done, ed);
      check(rd_data == exp_d, ev ? "R1 R2 R4 burst word" : "R6 R8 idle data", rd_data, exp_d);
    end
  endtask

  initial begin
    repeat (3) @(negedge rd_clk);
    check(rd_valid == 1'b0, "R9 reset valid", rd_valid, 0);
    check(rd_done == 1'b0, "R9 reset done", rd_done, 0);
    check(rd_data == '0, "R9 reset data", rd_data, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge rd_clk);
    check(rd_valid == 1'b0, "R9 no start after reset", rd_valid, 0);
    write_frame(1, 256, 1'b0);
    read_frame(1);
    write_frame(2, 300, 1'b1);
    read_frame(2);
    write_frame(3, 256, 1'b1);
    read_frame(3);
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule